// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block generates a slow converter clock from the bus clock. Two 4-bit counts are held in one control register. The high count sets how many bus-clock periods the output stays high. The low count sets how many it stays low. The output period is therefore the sum of the two counts, and the ratio of the two counts sets the duty cycle. If either count is zero, no clock is produced.

The control register has an interlock. A write is taken only while the converter reports itself both disabled and not holding a finished result, which means the output never changes shape mid-conversion. An accepted write restarts the waveform at the beginning of a high phase. The register reads back continuously on a plain output bus. The block has no streaming data path, so every pin is plain control or status.

Top module: `dutyclk_gen`

## Requirements
- R1: After reset both counts read zero, `rd_data` is 16'h0000 and `clk_out` is low.
- R2: With high count H and low count L both non-zero, `clk_out` repeats a pattern of H bus cycles high followed by L bus cycles low, so the period is H+L.
- R3: A write strobe while `conv_enable` or `conv_ready` is 1 is ignored: `rd_data` keeps its value and the running `clk_out` pattern continues without a restart.
- R4: While the high count or the low count is zero, `clk_out` stays low.
- R5: The high count is at `wr_data[7:4]` and the low count is at `wr_data[3:0]`; `rd_data[7:0]` returns these fields and `rd_data[15:8]` always reads zero.
- R6: An accepted write with both new counts non-zero makes `clk_out` high in the first cycle after the write edge, and a full high phase follows.
- R7: The largest counts, 15 and 15, give 15 cycles high and 15 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| conv_enable | input | 1 | Converter enable status; a 1 blocks writes |
| conv_ready | input | 1 | Conversion-ready status; a 1 blocks writes |
| clk_out | output | 1 | Generated clock |
| rd_data | output | 16 | Register readback |

## Verification
A phase counter that has slipped stretches or shortens a high or low run. This shows up on `clk_out` within one output period. A missing restart is visible in the first cycle after a write. A broken interlock changes `rd_data` in the cycle after the blocked strobe, and it also breaks the continuing pattern within a few cycles. A bad zero-count guard shows as a high `clk_out` right after a zero field is loaded.

// File: rtl/dutyclk_pkg.sv
package dutyclk_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned REG_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } dc_cfg_t;
endpackage

// File: rtl/dutyclk_cfg_reg.sv
module dutyclk_cfg_reg
  import dutyclk_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  input  logic          conv_enable,
  input  logic          conv_ready,
  output dc_cfg_t       cfg,
  output logic          cfg_load,
  output logic [RW-1:0] rd_data
);
  localparam int unsigned FW = 2 * CNT_W;

  dc_cfg_t cfg_q;

  // write only while the converter is idle
  assign cfg_load = wr_en & ~conv_enable & ~conv_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_load) begin
      cfg_q <= dc_cfg_t'(wr_data[FW-1:0]);
    end
  end

  assign cfg = cfg_q;

  generate
    if (RW > FW) begin : g_pad
      assign rd_data = {{(RW-FW){1'b0}}, cfg_q};
    end else begin : g_nopad
      assign rd_data = cfg_q;
    end
  endgenerate
endmodule

// File: rtl/dutyclk_phase_ctr.sv
module dutyclk_phase_ctr
  import dutyclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dc_cfg_t cfg,
  input  logic    restart,
  output logic    clk_out
);
  logic             phase_hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run;
  logic [CNT_W-1:0] limit;

  assign run   = (cfg.hi != '0) && (cfg.lo != '0);
  assign limit = phase_hi_q ? cfg.hi : cfg.lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi_q <= 1'b1;
      cnt_q      <= '0;
    end else if (restart || !run) begin
      phase_hi_q <= 1'b1;
      cnt_q      <= '0;
    end else if (cnt_q == limit - 1'b1) begin
      phase_hi_q <= ~phase_hi_q;
      cnt_q      <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_out = phase_hi_q & run;
endmodule

// File: rtl/dutyclk_gen.sv
module dutyclk_gen
  import dutyclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             conv_enable,
  input  logic             conv_ready,
  output logic             clk_out,
  output logic [REG_W-1:0] rd_data
);
  dc_cfg_t cfg;
  logic    cfg_load;

  dutyclk_cfg_reg #(.RW(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_enable(conv_enable), .conv_ready(conv_ready),
    .cfg(cfg), .cfg_load(cfg_load), .rd_data(rd_data)
  );

  dutyclk_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .restart(cfg_load), .clk_out(clk_out)
  );
endmodule

// File: rtl/dutyclk_gen_chk.sv
module dutyclk_gen_chk
  import dutyclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             conv_enable,
  input logic             conv_ready,
  input logic             clk_out,
  input logic [REG_W-1:0] rd_data
);
  logic       accept;
  logic [4:0] hi_run;

  assign accept = wr_en && !conv_enable && !conv_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_run <= '0;
    else if (accept)     hi_run <= '0;
    else if (clk_out)    hi_run <= (hi_run == 5'h1f) ? hi_run : hi_run + 1'b1;
    else                 hi_run <= '0;
  end

  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:4] == 4'd0 || rd_data[3:0] == 4'd0) |-> !clk_out);

  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (conv_enable || conv_ready)) |=> $stable(rd_data));

  p_restart_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_data[7:4] != 4'd0 && wr_data[3:0] != 4'd0) |=> clk_out);

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h00);

  p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> ({1'b0, rd_data[7:4]} > hi_run));
endmodule

bind dutyclk_gen dutyclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .conv_enable(conv_enable), .conv_ready(conv_ready),
  .clk_out(clk_out), .rd_data(rd_data)
);

// File: tb/dutyclk_gen_tb.sv
module dutyclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        conv_enable = 1'b0;
  logic        conv_ready = 1'b0;
  logic        clk_out;
  logic [15:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit          exp_q[$];
  string       tag_q[$];

  dutyclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_enable(conv_enable), .conv_ready(conv_ready),
    .clk_out(clk_out), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected clk_out sample per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {15'd0, clk_out}, {15'd0, e});
    end
  end

  task automatic push_pattern(int hi, int lo, int periods, string req);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < hi; i++) begin exp_q.push_back(1'b1); tag_q.push_back(req); end
      for (int i = 0; i < lo; i++) begin exp_q.push_back(1'b0); tag_q.push_back(req); end
    end
  endtask

  task automatic push_low(int n, string req);
    for (int i = 0; i < n; i++) begin exp_q.push_back(1'b0); tag_q.push_back(req); end
  endtask

  // driver: accepted write, then expected waveform into the scoreboard
  task automatic write_cfg(logic [15:0] d, int periods, string req);
    wait (exp_q.size() == 0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (d[7:4] == 0 || d[3:0] == 0) push_low(8, req);
    else push_pattern(int'(d[7:4]), int'(d[3:0]), periods, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 clk_out", {15'd0, clk_out}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 clk_out after release", {15'd0, clk_out}, 16'h0000);

    // R2/R6 basic asymmetric pattern, restart high
    write_cfg(16'h0032, 3, "R2 R6 h3l2");
    @(negedge clk);
    check("R5 readback", rd_data, 16'h0032);
    write_cfg(16'h0011, 4, "R2 h1l1");
    write_cfg(16'h0014, 3, "R2 h1l4");

    // R5 reserved bits dropped
    write_cfg(16'hA525, 2, "R5 R2 h2l5");
    @(negedge clk);
    check("R5 reserved zero", rd_data, 16'h0025);

    // R3 blocked writes during a running pattern
    write_cfg(16'h0032, 4, "R3 pattern continues");
    repeat (3) @(negedge clk);
    conv_ready = 1'b1; wr_en = 1'b1; wr_data = 16'h0011;
    @(posedge clk); #1;
    wr_en = 1'b0; conv_ready = 1'b0;
    @(negedge clk);
    check("R3 ready blocks", rd_data, 16'h0032);
    conv_enable = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
    @(posedge clk); #1;
    wr_en = 1'b0; conv_enable = 1'b0;
    @(negedge clk);
    check("R3 enable blocks", rd_data, 16'h0032);

    // R4 zero counts
    write_cfg(16'h0050, 1, "R4 low zero");
    write_cfg(16'h0006, 1, "R4 high zero");
    @(negedge clk);
    check("R4 readback", rd_data, 16'h0006);

    // R7 maximum counts
    write_cfg(16'h00FF, 2, "R7 h15l15");
    write_cfg(16'h0061, 2, "R6 R2 h6l1");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule